// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional 8-bit buses, called A and B. Each side has its own holding register and its own capture clock. The A register samples the A bus and the B register samples the B bus on every rising edge of the matching clock. These captures never depend on the output controls.

Whichever bus is being driven receives the bitwise complement of a source chosen per direction. That source is either the live value on the opposite bus or the opposite side's stored register. A shared active-low drive enable and a direction bit pick which single bus is driven, if any.

Each tri-state bus is split into three signals: a data-in vector, a data-out vector and one drive-enable bit. This keeps the block synthesizable. The pad drivers are left to the integration level.

Top module: `regbus_xcvr`

## Requirements
- R1: The data width is the parameter `WIDTH`, which defaults to 8. While `rst_n` is low at a rising edge of a capture clock, the register on that side clears to zero. As a result, right after reset a stored-mode output reads all ones.
- R2: The A register takes the value of `a_in` on each rising edge of `a_cap_clk` and holds it between edges.
- R3: The B register takes the value of `b_in` on each rising edge of `b_cap_clk` and holds it between edges.
- R4: Register capture takes place whatever the values of `drv_en_n`, `xfer_to_b`, `a2b_stored` and `b2a_stored`, including while both buses are isolated.
- R5: When `drv_en_n` is 1, both `a_oe` and `b_oe` are 0.
- R6: When `drv_en_n` is 0 and `xfer_to_b` is 1, `b_oe` is 1 and `a_oe` is 0.
- R7: When `drv_en_n` is 0 and `xfer_to_b` is 0, `a_oe` is 1 and `b_oe` is 0.
- R8: When `a2b_stored` is 0, `b_out` equals the bitwise inverse of `a_in` and follows it with no clock edge.
- R9: When `a2b_stored` is 1, `b_out` equals the bitwise inverse of the A register. A rising edge of `a_cap_clk` loads the register and updates `b_out` in the same step.
- R10: `b2a_stored` chooses the source for `a_out` in the same way. A value of 0 gives the inverse of `b_in`, and a value of 1 gives the inverse of the B register.
- R11: A change on `a2b_stored` or `b2a_stored` switches the driven output between live and stored data at once, without waiting for a clock edge.
- R12: `a_oe` and `b_oe` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_cap_clk | input | 1 | Rising edge loads the A register from `a_in` |
| b_cap_clk | input | 1 | Rising edge loads the B register from `b_in` |
| rst_n | input | 1 | Synchronous active-low reset, sampled on each capture clock |
| drv_en_n | input | 1 | Active-low drive enable; 1 isolates both buses |
| xfer_to_b | input | 1 | 1 drives the B bus, 0 drives the A bus |
| a2b_stored | input | 1 | Source for B: 0 live A bus, 1 A register |
| b2a_stored | input | 1 | Source for A: 0 live B bus, 1 B register |
| a_in | input | WIDTH | Value received from the A bus |
| b_in | input | WIDTH | Value received from the B bus |
| a_out | output | WIDTH | Value offered to the A bus (inverted source) |
| a_oe | output | 1 | Drive enable for the A bus |
| b_out | output | WIDTH | Value offered to the B bus (inverted source) |
| b_oe | output | 1 | Drive enable for the B bus |

## Verification
The bench first applies directed patterns, each aimed at one distinction:
- An all-ones value captured while the block is isolated, then read back through stored mode, shows that capture ignores the enables.
- A new bus value with no clock edge separates live from stored sourcing.
- A select toggle between edges shows that switching needs no clock.
- Walking the direction bit covers every row of the enable table.

After that, random bus data, controls and clock-edge choices cover mixed cases. These include edges on one clock only, edges on both clocks together, and edges during isolation. Each case is compared against a bench model of both registers and the truth table.

// File: rtl/xcvr_pkg.sv
// Package: shared types for the registered bus transceiver.
// Assumes: no state; it only names the per-direction source choice.
package xcvr_pkg;
    localparam int DEF_WIDTH = 8;

    // Source feeding the driven bus for one direction
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;
endpackage

// File: rtl/xcvr_store_reg.sv
// Module: one side's holding register.
// Purpose: samples the bus on every rising clock edge, with no enable.
// Assumes: rst_n is synchronous and active low, and needs one clock edge to act.
module xcvr_store_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Capture the bus unconditionally; clear it while in reset
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (q == '0)); // R1
    AST_CAPTURE_EVERY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (q == $past(d))); // R4
endmodule

// File: rtl/xcvr_drive_path.sv
// Module: source select and inversion for one direction.
// Purpose: offers the complement of either the live bus or the stored register.
// Assumes: purely combinational, so a select change takes effect with no clock.
module xcvr_drive_path
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    input  src_sel_e         sel,
    output logic [WIDTH-1:0] drive
);
    // Choose the source, then invert every bit
    always_comb begin
        if (sel == SRC_STORED) drive = ~stored;
        else                   drive = ~live;
    end
endmodule

// File: rtl/xcvr_dir_ctrl.sv
// Module: enable decode for the two buses.
// Purpose: drives at most one bus, chosen by the direction bit, when enabled.
// Assumes: drv_en_n is active low; isolation overrides direction.
module xcvr_dir_ctrl (
    input  logic drv_en_n,
    input  logic xfer_to_b,
    output logic a_oe,
    output logic b_oe
);
    // Decode the drive enables from enable and direction
    always_comb begin
        a_oe = 1'b0;
        b_oe = 1'b0;
        if (!drv_en_n) begin
            if (xfer_to_b) b_oe = 1'b1;
            else           a_oe = 1'b1;
        end
    end
endmodule

// File: rtl/regbus_xcvr.sv
// Module: registered bidirectional bus transceiver, top level.
// Purpose: one holding register per bus, plus a per-direction live/stored
//          inverting path, plus the enable decode.
// Assumes: each tri-state bus is split into in, out and oe. Index 0 of the
//          internal arrays is side A and index 1 is side B. Each register
//          resets on its own clock.
module regbus_xcvr
    import xcvr_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             a_cap_clk,
    input  logic             b_cap_clk,
    input  logic             rst_n,
    input  logic             drv_en_n,
    input  logic             xfer_to_b,
    input  logic             a2b_stored,
    input  logic             b2a_stored,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);
    localparam int NSIDE = 2;

    logic [NSIDE-1:0] cap_clk;
    logic [NSIDE-1:0] src_stored;
    logic [WIDTH-1:0] bus_in  [NSIDE];
    logic [WIDTH-1:0] reg_q   [NSIDE];
    logic [WIDTH-1:0] bus_out [NSIDE];

    // Gather the per-side inputs into indexed form
    always_comb begin
        cap_clk    = {b_cap_clk, a_cap_clk};
        src_stored = {b2a_stored, a2b_stored};
        bus_in[0]  = a_in;
        bus_in[1]  = b_in;
    end

    // One register and one drive path per side; side s feeds the other side
    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        xcvr_store_reg #(.WIDTH(WIDTH)) u_reg (
            .clk   (cap_clk[s]),
            .rst_n (rst_n),
            .d     (bus_in[s]),
            .q     (reg_q[s])
        );
        xcvr_drive_path #(.WIDTH(WIDTH)) u_path (
            .live   (bus_in[s]),
            .stored (reg_q[s]),
            .sel    (src_sel_e'(src_stored[s])),
            .drive  (bus_out[NSIDE-1-s])
        );
    end

    xcvr_dir_ctrl u_dir (
        .drv_en_n  (drv_en_n),
        .xfer_to_b (xfer_to_b),
        .a_oe      (a_oe),
        .b_oe      (b_oe)
    );

    // Present the indexed outputs on the named ports
    always_comb begin
        a_out = bus_out[0];
        b_out = bus_out[1];
    end

    AST_ISOLATE: assert property (@(posedge a_cap_clk) disable iff (!rst_n)
        drv_en_n |-> (!a_oe && !b_oe)); // R5
    AST_DRIVE_B: assert property (@(posedge a_cap_clk) disable iff (!rst_n)
        (!drv_en_n && xfer_to_b) |-> (b_oe && !a_oe)); // R6
    AST_DRIVE_A: assert property (@(posedge b_cap_clk) disable iff (!rst_n)
        (!drv_en_n && !xfer_to_b) |-> (a_oe && !b_oe)); // R7
    AST_OE_EXCLUSIVE: assert property (@(posedge a_cap_clk) disable iff (!rst_n)
        !(a_oe && b_oe)); // R12
    AST_A2B_LIVE: assert property (@(posedge a_cap_clk) disable iff (!rst_n)
        !a2b_stored |-> (b_out == ~a_in)); // R8
    AST_A2B_STORED: assert property (@(posedge a_cap_clk) disable iff (!rst_n)
        ($past(rst_n) && a2b_stored) |-> (b_out == ~$past(a_in))); // R9
    AST_B2A_STORED: assert property (@(posedge b_cap_clk) disable iff (!rst_n)
        ($past(rst_n) && b2a_stored) |-> (a_out == ~$past(b_in))); // R10
endmodule

// File: tb/regbus_xcvr_test.sv
module regbus_xcvr_test;
    localparam int W = 8;

    logic clk = 1'b0;
    logic g_ab = 1'b0, g_ba = 1'b0;
    logic rst_n = 1'b0;
    logic drv_en_n = 1'b1, xfer_to_b = 1'b0, a2b_stored = 1'b0, b2a_stored = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic a_oe, b_oe;
    logic a_cap_clk, b_cap_clk;
    logic [W-1:0] m_ra = '0, m_rb = '0;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;
    assign a_cap_clk = clk & g_ab;
    assign b_cap_clk = clk & g_ba;

    regbus_xcvr #(.WIDTH(W)) uut (
        .a_cap_clk(a_cap_clk), .b_cap_clk(b_cap_clk), .rst_n(rst_n),
        .drv_en_n(drv_en_n), .xfer_to_b(xfer_to_b),
        .a2b_stored(a2b_stored), .b2a_stored(b2a_stored),
        .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    function automatic logic [W-1:0] exp_b_out();
        return ~(a2b_stored ? m_ra : a_in);
    endfunction
    function automatic logic [W-1:0] exp_a_out();
        return ~(b2a_stored ? m_rb : b_in);
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Full compare against the truth-table model; outputs only when driven
    task automatic check_all(input string req);
        #1;
        check({req, " a_oe (R5 R6 R7 R12)"}, W'(a_oe), W'(!drv_en_n && !xfer_to_b));
        check({req, " b_oe (R5 R6 R7 R12)"}, W'(b_oe), W'(!drv_en_n && xfer_to_b));
        if (!drv_en_n && xfer_to_b)  check({req, " b_out (R8 R9)"}, b_out, exp_b_out());
        if (!drv_en_n && !xfer_to_b) check({req, " a_out (R10)"}, a_out, exp_a_out());
    endtask

    // One clock cycle with chosen capture edges; the model loads at the edge
    task automatic tick(input logic cab, input logic cba);
        @(negedge clk);
        g_ab = cab; g_ba = cba;
        @(posedge clk);
        if (rst_n) begin
            if (cab) m_ra = a_in;
            if (cba) m_rb = b_in;
        end else begin
            if (cab) m_ra = '0;
            if (cba) m_rb = '0;
        end
        @(negedge clk);
        g_ab = 1'b0; g_ba = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog (R1..all) actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0648));
        // r1_: reset both registers, then stored mode reads all ones
        a_in = 8'h5A; b_in = 8'hC3;
        tick(1, 1); tick(1, 1); tick(1, 1);
        rst_n = 1'b1;
        drv_en_n = 0; a2b_stored = 1; b2a_stored = 1; xfer_to_b = 1;
        #1; check("R1 b_out after reset", b_out, 8'hFF);
        xfer_to_b = 0;
        #1; check("R1 a_out after reset", a_out, 8'hFF);

        // R4 / R5: capture while isolated, then read back via stored mode
        drv_en_n = 1; a_in = 8'hFF; b_in = 8'h81;
        check_all("R5 isolated");
        tick(1, 1);
        drv_en_n = 0; xfer_to_b = 1;
        #1; check("R4 R2 A captured while isolated", b_out, 8'h00);
        xfer_to_b = 0;
        #1; check("R4 R3 B captured while isolated", a_out, 8'h7E);

        // R2: no edge means no capture
        a_in = 8'h3C; xfer_to_b = 1;
        #1; check("R2 A held without edge", b_out, 8'h00);
        // R9: edge loads and drives in the same step
        tick(1, 0);
        check("R9 stored update on edge", b_out, 8'hC3);

        // R8: live mode follows a_in without a clock
        a2b_stored = 0;
        #1; check("R11 switch to live", b_out, ~8'h3C);
        a_in = 8'h96;
        #1; check("R8 live follows input", b_out, 8'h69);
        a2b_stored = 1;
        #1; check("R11 switch to stored", b_out, 8'hC3);

        // R10 / R3 / R7: mirrored direction
        xfer_to_b = 0; b2a_stored = 0; b_in = 8'h0F;
        #1; check("R10 live B to A", a_out, 8'hF0);
        check_all("R7 drive A");
        b2a_stored = 1;
        tick(0, 1);
        check("R3 R10 B stored on edge", a_out, 8'hF0);
        b_in = 8'hAA;
        tick(1, 0);
        check("R3 B held on A-only edge", a_out, 8'hF0);
        xfer_to_b = 1;
        check_all("R6 drive B");

        // Random mix of data, controls and edges
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            a_in = W'($urandom); b_in = W'($urandom);
            drv_en_n = 1'($urandom); xfer_to_b = 1'($urandom);
            a2b_stored = 1'($urandom); b2a_stored = 1'($urandom);
            tick(1'($urandom), 1'($urandom));
            check_all("R2 R3 R4 R8 R9 R10 random");
            a2b_stored = ~a2b_stored; b2a_stored = ~b2a_stored;
            check_all("R11 random select flip");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule